// File: doc/BRIEF.md
# Per-Bank GPIO Interrupt Detector

This block watches every pin of one GPIO bank and decides, pin by pin, whether an interrupt condition has occurred. Each pin has a three-bit trigger selection that chooses between single-edge, dual-edge and level sensing, plus the active polarity. A detected condition is latched in a per-pin status flag. Software clears a flag with a one-cycle clear strobe. The block raises one bank interrupt line whenever some flag is set whose pin is also enabled.

The inputs are already synchronized to the block clock. The register bus that holds the trigger, enable and clear values sits outside this block, and so does the pin drive path. The bank is organised as ports of pins. Each port gets one trigger word made of three byte-sized lanes.

Top module: `gpio_irq_detect_bank`

## Requirements
- R1: Port p owns `trig_cfg[24p+23:24p]`. For pin b of that port, bit b is the active polarity (1 = high or rising), bit 8+b selects edge sensing (1) or level sensing (0), and bit 16+b, when edge sensing is on, makes both directions count. The codes are: rising 0x000101, falling 0x000100, either edge 0x010100, high level 0x000001, low level 0x000000.
- R2: A rising-type pin sets its status on the clock edge where it is first sampled high after being low. The flag is visible one cycle after the input changes. A high-to-low change does not set it.
- R3: A falling-type pin sets its status on a high-to-low change only.
- R4: An either-edge pin sets its status on every change of its input.
- R5: A level-type pin sets its status on every cycle its input sits at the active level. A clear has no effect while that level persists. It takes effect once the input is inactive.
- R6: An edge-detected status stays set until a clear strobe for that pin, which zeroes it on the next clock edge. Strobes for other pins leave it alone.
- R7: When a clear strobe and a new qualifying edge land in the same cycle, the status ends up set.
- R8: `bank_irq` is high exactly when some pin has both its status and its `irq_en` bit set. The response is combinational on `irq_en`. Status is still recorded while a pin is disabled.
- R9: After reset every status flag is 0. A pin held at a non-idle level through reset does not produce an edge when reset is released.
- R10: A cycle in which a pin's trigger bits change does not detect an edge on that pin, even if the input changes in the same cycle. Normal detection resumes on the following cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset; the clock must run while it is held |
| pin_sync | input | NUM_PORTS*PINS_PER_PORT | Synchronized pin levels, pin index = port*PINS_PER_PORT + bit |
| trig_cfg | input | NUM_PORTS*3*PINS_PER_PORT | Trigger words, one three-lane word per port |
| irq_en | input | NUM_PORTS*PINS_PER_PORT | Per-pin enable toward the bank line |
| clr_stb | input | NUM_PORTS*PINS_PER_PORT | Per-pin clear strobe, active high for one cycle |
| irq_status | output | NUM_PORTS*PINS_PER_PORT | Latched per-pin status flags |
| bank_irq | output | 1 | Bank interrupt request |

## Verification
The bench builds the block with its default shape of four ports of eight pins. This places the highest pin (index 31) in the top lane of the last port's word, so the lane split is exercised at both ends of the trigger vector. The scenarios spread across ports 0, 1 and 3, and every check compares the full 32-bit status vector, so leakage of a trigger word or a clear strobe into a neighbouring pin is visible. The wide bank also lets pins that are enabled and disabled coexist while `bank_irq` is observed.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

   // Three selection bits of one pin, gathered from the three lanes.
   typedef struct packed {
      logic both;      // either direction counts (edge sensing only)
      logic edge_sel;  // 1 = edge sensing, 0 = level sensing
      logic pol;       // 1 = high / rising is active
   } trig_sel_t;

   localparam int TRIG_LANES = 3;

   typedef enum logic [1:0] {
      DET_LEVEL       = 2'd0,
      DET_SINGLE_EDGE = 2'd1,
      DET_DUAL_EDGE   = 2'd2
   } det_kind_e;

   function automatic det_kind_e classify(input trig_sel_t t);
      if (!t.edge_sel)
         return DET_LEVEL;
      else if (t.both)
         return DET_DUAL_EDGE;
      return DET_SINGLE_EDGE;
   endfunction

endpackage

// File: rtl/gpio_irq_lane_split.sv
module gpio_irq_lane_split
   import gpio_irq_pkg::*;
#(
   parameter int PINS_PER_PORT = 8,
   localparam int WORD_W = TRIG_LANES * PINS_PER_PORT
)(
   input  logic [WORD_W-1:0]                  word,
   output trig_sel_t [PINS_PER_PORT-1:0]      sel
);

   // Lane 0 = polarity, lane 1 = edge select, lane 2 = dual-edge override.
   for (genvar b = 0; b < PINS_PER_PORT; b++) begin : g_pin
      assign sel[b].pol      = word[b];
      assign sel[b].edge_sel = word[PINS_PER_PORT + b];
      assign sel[b].both     = word[2*PINS_PER_PORT + b];
   end

endmodule

// File: rtl/gpio_irq_pin_det.sv
module gpio_irq_pin_det
   import gpio_irq_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      pin,
   input  trig_sel_t sel,
   input  logic      clr,
   output logic      status
);

   logic      prev_q;
   trig_sel_t sel_q;
   det_kind_e kind;
   logic      sel_moved;
   logic      toggled;
   logic      hit;
   logic      status_d;

   always_comb begin
      kind      = classify(sel);
      sel_moved = (sel != sel_q);
      toggled   = pin ^ prev_q;
      unique case (kind)
         DET_LEVEL:       hit = (pin == sel.pol);
         DET_SINGLE_EDGE: hit = toggled && (pin == sel.pol) && !sel_moved;
         DET_DUAL_EDGE:   hit = toggled && !sel_moved;
         default:         hit = 1'b0;
      endcase
      // A new hit outranks a clear arriving in the same cycle.
      status_d = hit | (status & ~clr);
   end

   // Synchronous reset: history loads the live input so release is silent.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prev_q <= pin;
         sel_q  <= sel;
         status <= 1'b0;
      end else begin
         prev_q <= pin;
         sel_q  <= sel;
         status <= status_d;
      end
   end

   AST_RISE_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
      (classify(sel) == DET_SINGLE_EDGE && sel.pol && $stable(sel) && $rose(pin)) |=> status); // R2
   AST_FALL_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
      (classify(sel) == DET_SINGLE_EDGE && !sel.pol && $stable(sel) && $fell(pin)) |=> status); // R3
   AST_DUAL_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
      (classify(sel) == DET_DUAL_EDGE && $stable(sel) && !$stable(pin)) |=> status); // R4
   AST_LEVEL_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
      (classify(sel) == DET_LEVEL && pin == sel.pol) |=> status); // R5
   AST_CLEAR_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
      (classify(sel) != DET_LEVEL && clr && $stable(pin) && $stable(sel)) |=> !status); // R6
   AST_CLEAR_RACE: assert property (@(posedge clk) disable iff (!rst_n)
      (classify(sel) == DET_SINGLE_EDGE && clr && $stable(sel) && !$stable(pin) && pin == sel.pol) |=> status); // R7
   AST_NO_CFG_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
      (classify(sel) != DET_LEVEL && !$stable(sel) && !status) |=> !status); // R10

endmodule

// File: rtl/gpio_irq_reduce.sv
module gpio_irq_reduce #(
   parameter int NPINS = 32
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NPINS-1:0] status,
   input  logic [NPINS-1:0] en,
   output logic             irq
);

   assign irq = |(status & en);

   AST_MASKED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      (en == '0) |-> !irq); // R8
   AST_IRQ_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (status != '0)); // R8

endmodule

// File: rtl/gpio_irq_detect_bank.sv
module gpio_irq_detect_bank
   import gpio_irq_pkg::*;
#(
   parameter int NUM_PORTS     = 4,
   parameter int PINS_PER_PORT = 8,
   localparam int NPINS  = NUM_PORTS * PINS_PER_PORT,
   localparam int WORD_W = TRIG_LANES * PINS_PER_PORT
)(
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [NPINS-1:0]            pin_sync,
   input  logic [NUM_PORTS*WORD_W-1:0] trig_cfg,
   input  logic [NPINS-1:0]            irq_en,
   input  logic [NPINS-1:0]            clr_stb,
   output logic [NPINS-1:0]            irq_status,
   output logic                        bank_irq
);

   if (NUM_PORTS < 1) begin : g_bad_ports
      $error("NUM_PORTS must be at least 1");
   end
   if (PINS_PER_PORT < 1 || PINS_PER_PORT > 32) begin : g_bad_width
      $error("PINS_PER_PORT must lie in 1..32");
   end

   for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
      trig_sel_t [PINS_PER_PORT-1:0] sel;

      gpio_irq_lane_split #(.PINS_PER_PORT(PINS_PER_PORT)) u_split (
         .word (trig_cfg[p*WORD_W +: WORD_W]),
         .sel  (sel)
      );

      for (genvar b = 0; b < PINS_PER_PORT; b++) begin : g_pin
         localparam int IDX = p * PINS_PER_PORT + b;
         gpio_irq_pin_det u_det (
            .clk    (clk),
            .rst_n  (rst_n),
            .pin    (pin_sync[IDX]),
            .sel    (sel[b]),
            .clr    (clr_stb[IDX]),
            .status (irq_status[IDX])
         );
      end
   end

   gpio_irq_reduce #(.NPINS(NPINS)) u_reduce (
      .clk    (clk),
      .rst_n  (rst_n),
      .status (irq_status),
      .en     (irq_en),
      .irq    (bank_irq)
   );

endmodule

// File: tb/gpio_irq_detect_bank_tb_top.sv
module gpio_irq_detect_bank_tb_top;

   localparam int NP   = 4;
   localparam int PPP  = 8;
   localparam int N    = NP * PPP;
   localparam int WW   = 3 * PPP;
   localparam int HALF = 2;   // 4 ns period, 250 MHz

   logic              clk = 1'b0;
   logic              rst_n;
   logic [N-1:0]      pin_sync;
   logic [NP*WW-1:0]  trig_cfg;
   logic [N-1:0]      irq_en;
   logic [N-1:0]      clr_stb;
   logic [N-1:0]      irq_status;
   logic              bank_irq;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;

   always #HALF clk = ~clk;

   gpio_irq_detect_bank #(.NUM_PORTS(NP), .PINS_PER_PORT(PPP)) dut_i (
      .clk(clk), .rst_n(rst_n), .pin_sync(pin_sync), .trig_cfg(trig_cfg),
      .irq_en(irq_en), .clr_stb(clr_stb), .irq_status(irq_status), .bank_irq(bank_irq)
   );

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // Codes per R1: {both, edge, pol}
   task automatic set_type(int p, bit bo, bit ed, bit pl);
      int base = (p / PPP) * WW;
      int b    = p % PPP;
      trig_cfg[base + b]         = pl;
      trig_cfg[base + PPP + b]   = ed;
      trig_cfg[base + 2*PPP + b] = bo;
   endtask

   task automatic pulse_clr(int p);
      clr_stb[p] = 1'b1;
      tick();
      clr_stb[p] = 1'b0;
   endtask

   task automatic t_reset();
      rst_n    = 1'b0;
      pin_sync = 32'hA5A5_5A5A;
      irq_en   = '1;
      clr_stb  = '0;
      trig_cfg = '0;
      for (int i = 0; i < N; i++) set_type(i, 0, 1, 1);
      repeat (3) tick();
      rst_n = 1'b1;
      repeat (3) tick();
      check("R9 status after reset", irq_status, 0);
      check("R9 bank line after reset", bank_irq, 0);
      pin_sync = '0;
      tick();
      check("R2 falling ignored in rising mode", irq_status, 0);
   endtask

   task automatic t_rising();
      pin_sync[3] = 1'b1;
      tick();
      check("R2 rising sets status", irq_status, 32'h8);
      check("R8 bank line raised", bank_irq, 1);
      repeat (3) tick();
      check("R6 status sticky", irq_status, 32'h8);
      pulse_clr(4);
      check("R6 other clear ignored", irq_status, 32'h8);
      pulse_clr(3);
      check("R6 clear zeroes status", irq_status, 0);
      check("R8 bank line dropped", bank_irq, 0);
   endtask

   task automatic t_falling();
      set_type(12, 0, 1, 0);
      tick();
      pin_sync[12] = 1'b1;
      tick();
      check("R3 rise ignored in falling mode", irq_status, 0);
      pin_sync[12] = 1'b0;
      tick();
      check("R3 fall sets status", irq_status, 32'h1000);
      pulse_clr(12);
      check("R3 cleared", irq_status, 0);
   endtask

   task automatic t_both();
      set_type(31, 1, 1, 0);
      tick();
      pin_sync[31] = 1'b1;
      tick();
      check("R4 rise on pin 31 (R1 top lane)", irq_status, 32'h8000_0000);
      pulse_clr(31);
      check("R4 cleared", irq_status, 0);
      pin_sync[31] = 1'b0;
      tick();
      check("R4 fall on pin 31", irq_status, 32'h8000_0000);
      pulse_clr(31);
      set_type(31, 0, 1, 1);
      tick();
      check("R4 idle after restore", irq_status, 0);
   endtask

   task automatic t_level();
      set_type(30, 0, 0, 1);
      tick();
      check("R5 level high inactive", irq_status, 0);
      pin_sync[30] = 1'b1;
      tick();
      check("R5 level high sets", irq_status, 32'h4000_0000);
      clr_stb[30] = 1'b1;
      tick();
      check("R5 clear held off while active", irq_status, 32'h4000_0000);
      pin_sync[30] = 1'b0;
      tick();
      clr_stb[30] = 1'b0;
      check("R5 clear after inactive", irq_status, 0);
      set_type(30, 0, 1, 1);
      // level low on pin 5, input already low
      set_type(5, 0, 0, 0);
      tick();
      check("R5 level low sets", irq_status, 32'h20);
      pin_sync[5] = 1'b1;
      tick();
      check("R5 status held after inactive", irq_status, 32'h20);
      pulse_clr(5);
      check("R5 level low cleared", irq_status, 0);
      set_type(5, 0, 1, 1);
      tick();
      pin_sync[5] = 1'b0;
      tick();
      check("R5 restore quiet", irq_status, 0);
   endtask

   task automatic t_race();
      pin_sync[3] = 1'b0;
      tick();
      pin_sync[3] = 1'b1;
      clr_stb[3]  = 1'b1;
      tick();
      clr_stb[3]  = 1'b0;
      check("R7 edge beats clear", irq_status, 32'h8);
      pin_sync[3] = 1'b0;
      tick();
      pin_sync[3] = 1'b1;
      clr_stb[3]  = 1'b1;
      tick();
      clr_stb[3]  = 1'b0;
      check("R7 set status survives clear with edge", irq_status, 32'h8);
      pulse_clr(3);
      pin_sync[3] = 1'b0;
      tick();
   endtask

   task automatic t_enable();
      irq_en = '0;
      pin_sync[3] = 1'b1;
      tick();
      check("R8 status recorded while disabled", irq_status, 32'h8);
      check("R8 disabled pin silent", bank_irq, 0);
      irq_en = ~32'h8;
      #1;
      check("R8 other enables do not help", bank_irq, 0);
      irq_en = 32'h8;
      #1;
      check("R8 enabling raises line", bank_irq, 1);
      irq_en = '1;
      pulse_clr(3);
      check("R8 line low after clear", bank_irq, 0);
   endtask

   task automatic t_type_change();
      set_type(9, 0, 1, 0);
      tick();
      pin_sync[9] = 1'b1;
      set_type(9, 0, 1, 1);
      tick();
      check("R10 no edge on type change cycle", irq_status, 0);
      pin_sync[9] = 1'b0;
      tick();
      pin_sync[9] = 1'b1;
      tick();
      check("R10 detection resumes", irq_status, 32'h200);
      pulse_clr(9);
      check("R10 cleared", irq_status, 0);
   endtask

   initial begin
      t_reset();
      t_rising();
      t_falling();
      t_both();
      t_level();
      t_race();
      t_enable();
      t_type_change();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      #(2 * HALF * 20000);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

endmodule